// File: doc/BRIEF.md
# Threshold Data FIFO with DMA Request Routing

This block is a 32-deep, 16-bit data buffer between a processor/DMA register port and the serial side of a card data path. In the receive direction the card side fills the buffer and the processor side drains it. In the transmit direction the roles are swapped. A single configuration word sets a high-water level and a low-water level, and it holds one DMA enable for each direction.

When the fill count crosses the level that belongs to the current direction, the block signals it. If that direction's DMA enable is set, it raises the DMA request line. If not, it raises a status flag that an interrupt controller can use. The request lines and the flags depend only on the present fill count, configuration and direction. They all drop while no transfer is active and the buffer is empty.

A write into a full buffer is discarded. A read from an empty buffer returns the word at the read pointer and leaves the pointer where it is.

Top module: `xfer_fifo`

## Requirements
- R1: After reset the fill level is 0, the configuration readback is 0x1F00 (high-water level 31, low-water level 0, both DMA enables 0), and both request lines and both flags are low.
- R2: The configuration word holds the receive DMA enable in bit 15, the high-water level in bits 12:8, the transmit DMA enable in bit 7 and the low-water level in bits 4:0. All other bits read back as 0.
- R3: Words leave the buffer in the order they entered, and `level_o` follows every accepted push and pop.
- R4: A push while the level is 32 is discarded. The level stays at 32 and the stored words are unchanged.
- R5: A pop while the level is 0 leaves the level at 0 and does not move the read pointer. `rdata_o` keeps showing the word stored at the read pointer.
- R6: In receive direction (`dir_rx_i`=1), when the level is greater than the high-water level, `rx_dreq_o` is high if receive DMA is enabled. Otherwise `afull_flag_o` is high.
- R7: In transmit direction (`dir_rx_i`=0), when the level is less than the low-water level, `tx_dreq_o` is high if transmit DMA is enabled. Otherwise `aempty_flag_o` is high.
- R8: When a direction's level condition is false, or the other direction is selected, that direction's request line and flag are both low.
- R9: While `xfer_active_i` is 0 and the level is 0, all request lines and flags are low.
- R10: Writing a configuration word that sets a direction's DMA enable clears that direction's flag from the next cycle.
- R11: In receive direction the buffer is pushed by `card_push_i` and popped by `cpu_rd_i`, and `cpu_wr_i` and `card_pop_i` are ignored. In transmit direction it is pushed by `cpu_wr_i` and popped by `card_pop_i`, and `card_push_i` and `cpu_rd_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_rx_i | input | 1 | 1 = receive (card to processor), 0 = transmit |
| xfer_active_i | input | 1 | A data transfer is in progress |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 16 | Configuration word write data |
| cfg_rdata_o | output | 16 | Configuration word readback |
| cpu_wr_i | input | 1 | Processor-side push strobe (transmit) |
| cpu_wdata_i | input | 16 | Processor-side push data |
| cpu_rd_i | input | 1 | Processor-side pop strobe (receive) |
| card_push_i | input | 1 | Card-side push strobe (receive) |
| card_wdata_i | input | 16 | Card-side push data |
| card_pop_i | input | 1 | Card-side pop strobe (transmit) |
| rdata_o | output | 16 | Word at the read pointer |
| level_o | output | 6 | Fill level, 0 to 32 |
| rx_dreq_o | output | 1 | Receive DMA request |
| tx_dreq_o | output | 1 | Transmit DMA request |
| afull_flag_o | output | 1 | High-water status flag |
| aempty_flag_o | output | 1 | Low-water status flag |

## Verification
The embedded properties check several things on every cycle. The level never exceeds 32 and a push into a full buffer leaves it at 32. An empty-buffer pop freezes both the level and the read pointer. A request and its flag are never high together, and the two directions never signal at the same time. The idle-and-empty state keeps every output low, and enabling DMA clears the matching flag on the next cycle. Only the directed scenarios can show the rest: the word order, that the dropped word really is absent, the exact crossing point of each water mark, the routing of the four strobes by direction, the bit layout of the configuration word, and the value returned by an underrun read.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  localparam int CFG_W         = 16;
  localparam int CFG_RX_EN_BIT = 15;
  localparam int CFG_HI_LSB    = 8;
  localparam int CFG_TX_EN_BIT = 7;
  localparam int CFG_LO_LSB    = 0;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/xfer_fifo_cfg.sv
module xfer_fifo_cfg
  import xfer_fifo_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             rx_en_o,
  output logic [LVL_W-1:0] hi_lvl_o,
  output logic             tx_en_o,
  output logic [LVL_W-1:0] lo_lvl_o,
  output logic [CFG_W-1:0] rdata_o
);
  localparam logic [LVL_W-1:0] HI_RST = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_o  <= 1'b0;
      tx_en_o  <= 1'b0;
      hi_lvl_o <= HI_RST;
      lo_lvl_o <= '0;
    end else if (we_i) begin
      rx_en_o  <= wdata_i[CFG_RX_EN_BIT];
      tx_en_o  <= wdata_i[CFG_TX_EN_BIT];
      hi_lvl_o <= wdata_i[CFG_HI_LSB +: LVL_W];
      lo_lvl_o <= wdata_i[CFG_LO_LSB +: LVL_W];
    end
  end

  always_comb begin
    rdata_o                        = '0;
    rdata_o[CFG_RX_EN_BIT]         = rx_en_o;
    rdata_o[CFG_TX_EN_BIT]         = tx_en_o;
    rdata_o[CFG_HI_LSB +: LVL_W]   = hi_lvl_o;
    rdata_o[CFG_LO_LSB +: LVL_W]   = lo_lvl_o;
  end
endmodule

// File: rtl/xfer_fifo_store.sv
module xfer_fifo_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, count_d;
  logic          push_ok, pop_ok;

  // full check is taken before any same-cycle pop
  assign push_ok = push_i && (count_q != FULL);
  assign pop_ok  = pop_i && (count_q != '0);

  always_comb begin
    unique case ({push_ok, pop_ok})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_ok) begin
      mem_q[wr_ptr_q] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL); // R4
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == FULL && push_i && !pop_i) |=> (count_q == FULL && $stable(wr_ptr_q))); // R4
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && pop_i && !push_i) |=> (count_q == '0 && $stable(rd_ptr_q))); // R5
endmodule

// File: rtl/xfer_fifo_thresh.sv
module xfer_fifo_thresh #(
  parameter int LVL_W = 5,
  localparam int CW   = LVL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    count_i,
  input  logic             dir_rx_i,
  input  logic             active_i,
  input  logic [LVL_W-1:0] hi_lvl_i,
  input  logic [LVL_W-1:0] lo_lvl_i,
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  output logic             rx_dreq_o,
  output logic             tx_dreq_o,
  output logic             hi_flag_o,
  output logic             lo_flag_o
);
  logic quiet, rx_hit, tx_hit;

  assign quiet  = !active_i && (count_i == '0);
  assign rx_hit = !quiet && dir_rx_i && (count_i > {1'b0, hi_lvl_i});
  assign tx_hit = !quiet && !dir_rx_i && (count_i < {1'b0, lo_lvl_i});

  // hit is steered to exactly one of request or flag
  assign rx_dreq_o = rx_hit && rx_en_i;
  assign hi_flag_o = rx_hit && !rx_en_i;
  assign tx_dreq_o = tx_hit && tx_en_i;
  assign lo_flag_o = tx_hit && !tx_en_i;

  AST_RX_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_dreq_o && hi_flag_o)); // R6
  AST_TX_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_dreq_o && lo_flag_o)); // R7
  AST_DIR_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((rx_dreq_o || hi_flag_o) && (tx_dreq_o || lo_flag_o))); // R8
endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo
  import xfer_fifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH),
  localparam int CW    = LVL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_rx_i,
  input  logic             xfer_active_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             cpu_wr_i,
  input  logic [DW-1:0]    cpu_wdata_i,
  input  logic             cpu_rd_i,
  input  logic             card_push_i,
  input  logic [DW-1:0]    card_wdata_i,
  input  logic             card_pop_i,
  output logic [DW-1:0]    rdata_o,
  output logic [CW-1:0]    level_o,
  output logic             rx_dreq_o,
  output logic             tx_dreq_o,
  output logic             afull_flag_o,
  output logic             aempty_flag_o
);
  xfer_dir_e        dir;
  logic             push, pop;
  logic [DW-1:0]    push_data;
  logic             rx_en, tx_en;
  logic [LVL_W-1:0] hi_lvl, lo_lvl;

  assign dir = xfer_dir_e'(dir_rx_i);

  always_comb begin
    if (dir == DIR_RX) begin
      push      = card_push_i;
      push_data = card_wdata_i;
      pop       = cpu_rd_i;
    end else begin
      push      = cpu_wr_i;
      push_data = cpu_wdata_i;
      pop       = card_pop_i;
    end
  end

  xfer_fifo_cfg #(.LVL_W(LVL_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .rx_en_o  (rx_en),
    .hi_lvl_o (hi_lvl),
    .tx_en_o  (tx_en),
    .lo_lvl_o (lo_lvl),
    .rdata_o  (cfg_rdata_o)
  );

  xfer_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (push_data),
    .pop_i   (pop),
    .rdata_o (rdata_o),
    .count_o (level_o)
  );

  xfer_fifo_thresh #(.LVL_W(LVL_W)) u_thresh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (level_o),
    .dir_rx_i  (dir_rx_i),
    .active_i  (xfer_active_i),
    .hi_lvl_i  (hi_lvl),
    .lo_lvl_i  (lo_lvl),
    .rx_en_i   (rx_en),
    .tx_en_i   (tx_en),
    .rx_dreq_o (rx_dreq_o),
    .tx_dreq_o (tx_dreq_o),
    .hi_flag_o (afull_flag_o),
    .lo_flag_o (aempty_flag_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_active_i && level_o == '0) |-> !(rx_dreq_o || tx_dreq_o || afull_flag_o || aempty_flag_o)); // R9
  AST_RX_EN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[CFG_RX_EN_BIT]) |=> !afull_flag_o); // R10
  AST_TX_EN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[CFG_TX_EN_BIT]) |=> !aempty_flag_o); // R10
endmodule

// File: tb/sim_xfer_fifo.sv
module sim_xfer_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_rx = 1'b0, active = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0, card_push = 1'b0, card_pop = 1'b0;
  logic [15:0] cpu_wdata = '0, card_wdata = '0, rdata;
  logic [5:0]  level;
  logic        rx_dreq, tx_dreq, afull, aempty;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xfer_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .dir_rx_i(dir_rx), .xfer_active_i(active),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata), .cpu_rd_i(cpu_rd),
    .card_push_i(card_push), .card_wdata_i(card_wdata), .card_pop_i(card_pop),
    .rdata_o(rdata), .level_o(level), .rx_dreq_o(rx_dreq), .tx_dreq_o(tx_dreq),
    .afull_flag_o(afull), .aempty_flag_o(aempty)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_outs(string req, logic rd, logic td, logic af, logic ae);
    chk(req, {rx_dreq, tx_dreq, afull, aempty}, {rd, td, af, ae});
  endtask

  task automatic cfg_wr(logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v; @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic cpu_push(logic [15:0] v);
    cpu_wr = 1'b1; cpu_wdata = v; @(negedge clk); cpu_wr = 1'b0;
  endtask
  task automatic crd_push(logic [15:0] v);
    card_push = 1'b1; card_wdata = v; @(negedge clk); card_push = 1'b0;
  endtask
  task automatic cpu_pop(string req, logic [15:0] exp);
    chk(req, rdata, exp); cpu_rd = 1'b1; @(negedge clk); cpu_rd = 1'b0;
  endtask
  task automatic crd_pop(string req, logic [15:0] exp);
    chk(req, rdata, exp); card_pop = 1'b1; @(negedge clk); card_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 level", level, 0);
    chk("R1 cfg", cfg_rdata, 16'h1F00);
    chk_outs("R1 outs", 0, 0, 0, 0);
  endtask

  task automatic t_cfg();
    cfg_wr(16'hFFFF);
    chk("R2 all ones", cfg_rdata, 16'h9F9F);
    cfg_wr(16'h6A55);
    chk("R2 pattern", cfg_rdata, 16'h0A15);
  endtask

  task automatic t_tx();
    dir_rx = 1'b0; active = 1'b1;
    cfg_wr(16'h0004);
    chk_outs("R7 empty below low mark", 0, 0, 0, 1);
    cpu_push(16'hA001); cpu_push(16'hA002); cpu_push(16'hA003);
    chk("R3 level 3", level, 3);
    chk_outs("R7 level 3", 0, 0, 0, 1);
    cpu_push(16'hA004);
    chk_outs("R8 level 4 at mark", 0, 0, 0, 0);
    crd_push(16'hBEEF);
    chk("R11 card push ignored in tx", level, 4);
    cpu_rd = 1'b1; @(negedge clk); cpu_rd = 1'b0;
    chk("R11 cpu pop ignored in tx", level, 4);
    crd_pop("R3 order", 16'hA001);
    chk_outs("R7 back below", 0, 0, 0, 1);
    crd_pop("R3 order", 16'hA002);
    crd_pop("R3 order", 16'hA003);
    crd_pop("R3 order", 16'hA004);
    chk("R3 drained", level, 0);
    cfg_wr(16'h0084);
    chk_outs("R10 tx enable clears flag", 0, 1, 0, 0);
    repeat (4) cpu_push(16'h0);
    chk_outs("R7 dma drops at mark", 0, 0, 0, 0);
    repeat (4) crd_pop("R3 drain", 16'h0);
    dir_rx = 1'b1; @(negedge clk);
    chk_outs("R8 direction change", 0, 0, 0, 0);
  endtask

  task automatic t_rx();
    dir_rx = 1'b1; active = 1'b1;
    cfg_wr(16'h0200);
    crd_push(16'hB001); crd_push(16'hB002);
    chk_outs("R8 level 2 not above", 0, 0, 0, 0);
    crd_push(16'hB003);
    chk_outs("R6 flag above mark", 0, 0, 1, 0);
    cpu_push(16'hCCCC);
    chk("R11 cpu write ignored in rx", level, 3);
    card_pop = 1'b1; @(negedge clk); card_pop = 1'b0;
    chk("R11 card pop ignored in rx", level, 3);
    cfg_wr(16'h8200);
    chk_outs("R10 rx enable clears flag", 1, 0, 0, 0);
    cpu_pop("R6 order", 16'hB001);
    chk_outs("R6 request drops", 0, 0, 0, 0);
    cpu_pop("R3 order", 16'hB002);
    cpu_pop("R3 order", 16'hB003);
  endtask

  task automatic t_idle();
    dir_rx = 1'b1; active = 1'b1;
    cfg_wr(16'h8000);
    crd_push(16'hC001);
    chk_outs("R6 above zero mark", 1, 0, 0, 0);
    active = 1'b0; @(negedge clk);
    chk_outs("R9 idle but not empty", 1, 0, 0, 0);
    cpu_pop("R3 order", 16'hC001);
    chk_outs("R9 idle and empty", 0, 0, 0, 0);
    dir_rx = 1'b0; cfg_wr(16'h0004);
    chk_outs("R9 tx idle empty", 0, 0, 0, 0);
    active = 1'b1; @(negedge clk);
    chk_outs("R9 tx active empty", 0, 0, 0, 1);
  endtask

  task automatic t_full_under();
    dir_rx = 1'b0; active = 1'b1;
    cfg_wr(16'h0000);
    for (int i = 0; i < 32; i++) cpu_push(16'h1000 + 16'(i));
    chk("R4 level full", level, 32);
    cpu_push(16'hDEAD);
    chk("R4 full write dropped", level, 32);
    for (int i = 0; i < 32; i++) crd_pop("R4 contents", 16'h1000 + 16'(i));
    chk("R4 drained", level, 0);
    chk("R5 head on empty", rdata, 16'h1000);
    card_pop = 1'b1; @(negedge clk); card_pop = 1'b0;
    chk("R5 level stays", level, 0);
    chk("R5 pointer kept", rdata, 16'h1000);
    cpu_push(16'h5A5A);
    chk("R5 next push at same slot", rdata, 16'h5A5A);
    crd_pop("R3 order", 16'h5A5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_tx();
    t_rx();
    t_idle();
    t_full_under();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule